// File: doc/BRIEF.md
# Programmable CRC Register Engine

A register-mapped checksum accelerator that computes 16-bit or 32-bit cyclic redundancy checks. Software programs a generator polynomial and a seed, then streams data through a single shared register. One control bit chooses what a write to that shared register does. When the bit is set, the write loads the seed. When the bit is clear, the write feeds data into the calculation.

Bits can be reordered on the fly as a data word is written and as the result is read. The input and output orderings are chosen independently. The result can also be inverted on read. Byte-lane strobes allow 8-, 16- and 32-bit data writes. Each enabled byte is folded into the checksum over a fixed number of clock cycles. While bytes are pending, the block raises `busy` and holds off further bus accesses through `bus_ready`.

Top module: `crc_regengine`

## Requirements
- R1: After reset, the control register reads 0 (16-bit mode, seed mode off, no reordering, no inversion), the polynomial register reads 0x04C11DB7, the CRC register holds 0xFFFFFFFF, and `busy` is low.
- R2: Word address 0 is the seed/data/result register, 1 is the polynomial and 2 is control. Control fields are: bit 0 width (1 = 32-bit), bit 1 seed mode, bits 3:2 input ordering, bits 5:4 output ordering, bit 6 invert. Polynomial writes honour the byte strobes. Control is written when strobe 0 is set.
- R3: With seed mode set, a write to address 0 copies the strobed bytes into the CRC register without reordering and without raising `busy`.
- R4: In 16-bit mode, a seed write clears CRC bits 31:16, reads of address 0 return 0 in bits 31:16, and only polynomial bits 15:0 take part in the calculation.
- R5: With seed mode clear, each strobed byte of a data write is folded into the CRC, highest lane first. Each byte is shifted in MSB-first against the polynomial of the selected width, and the result is written back to the CRC register.
- R6: An accepted data write with n strobed bytes holds `busy` high for 2·n cycles, starting the cycle after acceptance.
- R7: While `busy` is high, `bus_ready` is low and no access takes effect. A stalled access completes once `busy` falls.
- R8: The input ordering code applies to the 32-bit write word. 0 = unchanged, 1 = bits reversed inside each byte, 2 = all 32 bits reversed, 3 = byte order swapped. For codes 2 and 3 the byte strobes are reversed to match.
- R9: The output ordering code (same encoding) applies to the result read from address 0, within the selected width.
- R10: When invert is set, the read result is complemented within the selected width, after the output ordering.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_be | input | 4 | Byte-lane strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while the access is requested and ready |
| bus_ready | output | 1 | Access accepted at the next rising edge when high |
| busy | output | 1 | Bytes still being folded into the CRC |

## Verification
Read data is combinational, so the monitor compares it in the same cycle the access is presented and ready, half a cycle before the accepting edge. `busy` rises one cycle after a data write is accepted and falls exactly 2·n cycles later. The bench counts busy cycles at falling edges from the cycle after acceptance to compare against that figure. A read of the result issued straight after a data write stalls until the last byte is committed, so every result comparison sees the finished checksum.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned LANES  = WORD_W / 8;

   localparam int unsigned REG_DATA = 0;
   localparam int unsigned REG_POLY = 1;
   localparam int unsigned REG_CTRL = 2;

   typedef enum logic [1:0] {
      TP_NONE  = 2'd0,
      TP_BITS  = 2'd1,
      TP_ALL   = 2'd2,
      TP_BYTES = 2'd3
   } tp_e;

   typedef struct packed {
      logic inv;
      tp_e  out_tp;
      tp_e  in_tp;
      logic seed;
      logic wide;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

   function automatic logic [1:0] top_lane(input logic [LANES-1:0] m);
      logic [1:0] r;
      r = '0;
      for (int i = 0; i < int'(LANES); i++) begin
         if (m[i]) r = 2'(i);
      end
      return r;
   endfunction
endpackage

// File: rtl/crc_xpose.sv
module crc_xpose
   import crc_eng_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  tp_e          mode,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   localparam int unsigned NB = W / 8;

   if ((W % 8) != 0 || W < 16) begin : g_bad_w
      $error("crc_xpose: W must be a multiple of 8 and at least 16");
   end

   logic [W-1:0] v_all, v_bits, v_bytes;

   for (genvar i = 0; i < W; i++) begin : g_all
      assign v_all[i] = din[W-1-i];
   end

   for (genvar b = 0; b < NB; b++) begin : g_lane
      for (genvar k = 0; k < 8; k++) begin : g_bit
         assign v_bits[b*8+k]  = din[b*8+7-k];
         assign v_bytes[b*8+k] = din[(NB-1-b)*8+k];
      end
   end

   always_comb begin
      unique case (mode)
         TP_BITS:  dout = v_bits;
         TP_ALL:   dout = v_all;
         TP_BYTES: dout = v_bytes;
         default:  dout = din;
      endcase
   end
endmodule

// File: rtl/crc_step.sv
module crc_step
   import crc_eng_pkg::*;
(
   input  logic              wide,
   input  logic [WORD_W-1:0] crc,
   input  logic [WORD_W-1:0] poly,
   input  logic [7:0]        dat,
   output logic [WORD_W-1:0] nxt
);
   always_comb begin
      logic [WORD_W-1:0] c, p;
      c = wide ? crc  : {crc[15:0], 16'h0};
      p = wide ? poly : {poly[15:0], 16'h0};
      c = c ^ {dat, 24'h0};
      for (int i = 0; i < 8; i++) begin
         c = c[WORD_W-1] ? ({c[WORD_W-2:0], 1'b0} ^ p) : {c[WORD_W-2:0], 1'b0};
      end
      nxt = wide ? c : {16'h0, c[WORD_W-1:16]};
   end
endmodule

// File: rtl/crc_regengine.sv
module crc_regengine
   import crc_eng_pkg::*;
#(
   parameter logic [31:0] POLY_RST    = 32'h04C11DB7,
   parameter logic [31:0] SEED_RST    = 32'hFFFFFFFF,
   parameter int unsigned STEP_CYCLES = 2,
   parameter int unsigned ADDR_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_ready,
   output logic              busy
);
   localparam int unsigned PH_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;

   if (STEP_CYCLES < 1) begin : g_bad_step
      $error("crc_regengine: STEP_CYCLES must be at least 1");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("crc_regengine: ADDR_W must be at least 2");
   end

   ctrl_t             ctrl_q;
   logic [WORD_W-1:0] poly_q, crc_q, word_q;
   logic [LANES-1:0]  pend_q;
   logic [PH_W-1:0]   phase_q;

   logic              wr_acc, commit, mode_wide, mode_seed;
   logic              a_data, a_poly, a_ctrl;
   logic [1:0]        lane;
   logic [7:0]        cur_byte;
   logic [WORD_W-1:0] wd_tp, crc_nxt, seed_val, poly_val;
   logic [LANES-1:0]  be_rev, be_tp;
   logic [15:0]       res16;
   logic [WORD_W-1:0] res32, result;

   assign busy      = |pend_q;
   assign bus_ready = ~busy;
   assign wr_acc    = bus_sel & bus_wr & bus_ready;
   assign mode_wide = ctrl_q.wide;
   assign mode_seed = ctrl_q.seed;
   assign a_data    = (bus_addr == ADDR_W'(REG_DATA));
   assign a_poly    = (bus_addr == ADDR_W'(REG_POLY));
   assign a_ctrl    = (bus_addr == ADDR_W'(REG_CTRL));

   // input ordering on the write word, strobes follow the byte moves
   crc_xpose #(.W(WORD_W)) u_in_tp (
      .mode (ctrl_q.in_tp),
      .din  (bus_wdata),
      .dout (wd_tp)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_be_rev
      assign be_rev[i] = bus_be[LANES-1-i];
   end
   assign be_tp = (ctrl_q.in_tp == TP_ALL || ctrl_q.in_tp == TP_BYTES) ? be_rev : bus_be;

   // byte merge for seed and polynomial writes
   always_comb begin
      seed_val = crc_q;
      poly_val = poly_q;
      for (int i = 0; i < int'(LANES); i++) begin
         if (bus_be[i]) begin
            seed_val[i*8 +: 8] = bus_wdata[i*8 +: 8];
            poly_val[i*8 +: 8] = bus_wdata[i*8 +: 8];
         end
      end
      if (!ctrl_q.wide) seed_val[WORD_W-1:16] = '0;
   end

   // highest pending lane is folded next
   assign lane     = top_lane(pend_q);
   assign cur_byte = word_q[{lane, 3'b000} +: 8];
   assign commit   = busy && (phase_q == PH_W'(STEP_CYCLES - 1));

   crc_step u_step (
      .wide (ctrl_q.wide),
      .crc  (crc_q),
      .poly (poly_q),
      .dat  (cur_byte),
      .nxt  (crc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         poly_q  <= POLY_RST;
         crc_q   <= SEED_RST;
         word_q  <= '0;
         pend_q  <= '0;
         phase_q <= '0;
      end else if (wr_acc) begin
         if (a_data) begin
            if (ctrl_q.seed) begin
               crc_q <= seed_val;
            end else begin
               word_q  <= wd_tp;
               pend_q  <= be_tp;
               phase_q <= '0;
            end
         end else if (a_poly) begin
            poly_q <= poly_val;
         end else if (a_ctrl && bus_be[0]) begin
            ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
         end
      end else if (busy) begin
         if (commit) begin
            crc_q        <= crc_nxt;
            pend_q[lane] <= 1'b0;
            phase_q      <= '0;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end
   end

   // result path: ordering then inversion, within the selected width
   crc_xpose #(.W(16)) u_out16 (
      .mode (ctrl_q.out_tp),
      .din  (crc_q[15:0]),
      .dout (res16)
   );
   crc_xpose #(.W(WORD_W)) u_out32 (
      .mode (ctrl_q.out_tp),
      .din  (crc_q),
      .dout (res32)
   );

   always_comb begin
      if (ctrl_q.wide) result = res32 ^ {WORD_W{ctrl_q.inv}};
      else             result = {16'h0, res16 ^ {16{ctrl_q.inv}}};
   end

   always_comb begin
      if (a_data)      bus_rdata = result;
      else if (a_poly) bus_rdata = poly_q;
      else if (a_ctrl) bus_rdata = {{(WORD_W-CTRL_W){1'b0}}, ctrl_q};
      else             bus_rdata = '0;
   end
endmodule

// File: rtl/crc_regengine_chk.sv
module crc_regengine_chk #(
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned STEP_CYCLES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [3:0]        bus_be,
   input logic [31:0]       bus_rdata,
   input logic              bus_ready,
   input logic              busy,
   input logic              mode_wide,
   input logic              mode_seed
);
   logic acc_data_wr;
   assign acc_data_wr = bus_sel && bus_wr && bus_ready && (bus_addr == '0);

   assert_seed_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_data_wr && mode_seed) |=> !busy);

   assert_feed_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_data_wr && !mode_seed && (bus_be != 4'b0)) |=> busy);

   if (STEP_CYCLES >= 2) begin : g_min_busy
      assert_busy_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(busy) |=> busy);
   end

   assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !bus_ready);

   assert_idle_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> bus_ready);

   assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && (bus_addr == '0) && !mode_wide) |-> (bus_rdata[31:16] == 16'h0));
endmodule

bind crc_regengine crc_regengine_chk #(
   .ADDR_W      (ADDR_W),
   .STEP_CYCLES (STEP_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_be    (bus_be),
   .bus_rdata (bus_rdata),
   .bus_ready (bus_ready),
   .busy      (busy),
   .mode_wide (mode_wide),
   .mode_seed (mode_seed)
);

// File: tb/sim_crc_regengine.sv
module sim_crc_regengine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ready, busy;

   always #5 clk = ~clk;

   crc_regengine u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready), .busy(busy)
   );

   int compared = 0;
   int mismatched = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   // reference model state
   logic        m_wide, m_seed, m_inv;
   logic [1:0]  m_itp, m_otp;
   logic [31:0] m_poly, m_crc;

   function automatic logic [7:0] rb8(input logic [7:0] b);
      logic [7:0] r;
      for (int k = 0; k < 8; k++) r[k] = b[7-k];
      return r;
   endfunction

   function automatic logic [31:0] tp32(input logic [1:0] m, input logic [31:0] w);
      case (m)
         2'd1:    return {rb8(w[31:24]), rb8(w[23:16]), rb8(w[15:8]), rb8(w[7:0])};
         2'd2:    return {<<{w}};
         2'd3:    return {w[7:0], w[15:8], w[23:16], w[31:24]};
         default: return w;
      endcase
   endfunction

   function automatic logic [15:0] tp16(input logic [1:0] m, input logic [15:0] h);
      case (m)
         2'd1:    return {rb8(h[15:8]), rb8(h[7:0])};
         2'd2:    return {<<{h}};
         2'd3:    return {h[7:0], h[15:8]};
         default: return h;
      endcase
   endfunction

   function automatic logic [31:0] exp_res();
      if (m_wide) return tp32(m_otp, m_crc) ^ {32{m_inv}};
      return {16'h0, tp16(m_otp, m_crc[15:0]) ^ {16{m_inv}}};
   endfunction

   task automatic fold(input logic [7:0] b);
      logic fb;
      logic [15:0] c16;
      c16 = m_crc[15:0];
      for (int i = 7; i >= 0; i--) begin
         if (m_wide) begin
            fb = m_crc[31] ^ b[i];
            m_crc = {m_crc[30:0], 1'b0};
            if (fb) m_crc = m_crc ^ m_poly;
         end else begin
            fb = c16[15] ^ b[i];
            c16 = {c16[14:0], 1'b0};
            if (fb) c16 = c16 ^ m_poly[15:0];
         end
      end
      if (!m_wide) m_crc = {m_crc[31:16], c16};
   endtask

   task automatic bus_go(input logic w, input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_be = be; bus_wdata = d;
      #1;
      while (!bus_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
      logic [31:0] w;
      logic [3:0]  l;
      if (a == 2'd0) begin
         if (m_seed) begin
            for (int i = 0; i < 4; i++) if (be[i]) m_crc[i*8 +: 8] = d[i*8 +: 8];
            if (!m_wide) m_crc[31:16] = '0;
         end else begin
            w = tp32(m_itp, d);
            l = (m_itp >= 2'd2) ? {be[0], be[1], be[2], be[3]} : be;
            for (int i = 3; i >= 0; i--) if (l[i]) fold(w[i*8 +: 8]);
         end
      end else if (a == 2'd1) begin
         for (int i = 0; i < 4; i++) if (be[i]) m_poly[i*8 +: 8] = d[i*8 +: 8];
      end else if (a == 2'd2 && be[0]) begin
         m_wide = d[0]; m_seed = d[1]; m_itp = d[3:2]; m_otp = d[5:4]; m_inv = d[6];
      end
      bus_go(1'b1, a, be, d);
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      bus_go(1'b0, a, 4'hF, 32'h0);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] e);
      compared++;
      if (act !== e) begin
         mismatched++;
         $display("FAIL %s: got %h expected %h", tag, act, e);
      end
   endtask

   task automatic busy_len(output int n);
      n = 0;
      @(negedge clk);
      while (busy) begin
         n++;
         @(negedge clk);
      end
   endtask

   // monitor: compares every accepted read against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (bus_sel && !bus_wr && bus_ready) begin
            if (exp_q.size() == 0) begin
               compared++; mismatched++;
               $display("FAIL unexpected read: got %h expected none", bus_rdata);
            end else begin
               check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
         end
      end
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      compared++; mismatched++;
      $display("FAIL watchdog: got hung expected done");
      finish_run();
   end

   initial begin
      int n;
      m_wide = 0; m_seed = 0; m_itp = 0; m_otp = 0; m_inv = 0;
      m_poly = 32'h04C11DB7; m_crc = 32'hFFFFFFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      check("R1 busy", {31'h0, busy}, 32'h0);
      rd(2'd2, 32'h0, "R1 ctrl");
      rd(2'd1, 32'h04C11DB7, "R1 poly");
      rd(2'd0, 32'h0000FFFF, "R1 crc");

      // R2 polynomial byte strobe
      wr(2'd1, 4'b0100, 32'h00AA0000);
      rd(2'd1, 32'h04AA1DB7, "R2 poly lane");
      wr(2'd1, 4'hF, 32'h04C11DB7);

      // 32-bit reflected checksum over "123456789"
      wr(2'd2, 4'h1, 32'h67);
      wr(2'd0, 4'hF, 32'hFFFFFFFF);
      busy_len(n);
      check("R3 seed no busy", n, 0);
      wr(2'd2, 4'h1, 32'h65);
      rd(2'd2, 32'h65, "R2 ctrl readback");
      wr(2'd0, 4'hF, 32'h31323334);
      busy_len(n);
      check("R6 four bytes", n, 8);
      wr(2'd0, 4'hF, 32'h35363738);
      @(negedge clk);
      check("R7 ready low", {31'h0, bus_ready}, 32'h0);
      wr(2'd0, 4'b0001, 32'h00000039);
      busy_len(n);
      check("R6 one byte", n, 2);
      rd(2'd0, 32'hCBF43926, "R5 crc32 vector");

      // R9 / R10 output ordering and inversion
      wr(2'd2, 4'h1, 32'h75); rd(2'd0, exp_res(), "R9 byte swap inv");
      wr(2'd2, 4'h1, 32'h15); rd(2'd0, exp_res(), "R9 bit reverse");
      wr(2'd2, 4'h1, 32'h45); rd(2'd0, exp_res(), "R10 invert only");
      wr(2'd2, 4'h1, 32'h05); rd(2'd0, exp_res(), "R10 plain");

      // R8 input ordering
      wr(2'd2, 4'h1, 32'h03);
      wr(2'd0, 4'hF, 32'h00000000);
      wr(2'd2, 4'h1, 32'h09);
      wr(2'd0, 4'b0011, 32'h0000A5C3);
      busy_len(n);
      check("R6 two bytes", n, 4);
      rd(2'd0, exp_res(), "R8 full reverse");
      wr(2'd2, 4'h1, 32'h0D);
      wr(2'd0, 4'hF, 32'h12345678);
      rd(2'd0, exp_res(), "R8 byte swap");
      wr(2'd2, 4'h1, 32'h01);
      wr(2'd0, 4'b0100, 32'h00EE0000);
      rd(2'd0, exp_res(), "R5 single lane");

      // 16-bit mode, polynomial upper half ignored
      wr(2'd2, 4'h1, 32'h02);
      wr(2'd1, 4'hF, 32'hDEAD1021);
      wr(2'd0, 4'hF, 32'hABCDFFFF);
      rd(2'd0, 32'h0000FFFF, "R4 seed low half");
      wr(2'd2, 4'h1, 32'h00);
      wr(2'd0, 4'b0011, 32'h00003132);
      wr(2'd0, 4'b0011, 32'h00003334);
      wr(2'd0, 4'b0011, 32'h00003536);
      wr(2'd0, 4'b0011, 32'h00003738);
      wr(2'd0, 4'b0001, 32'h00000039);
      rd(2'd0, 32'h000029B1, "R4 R5 crc16 vector");
      wr(2'd2, 4'h1, 32'h60);
      rd(2'd0, exp_res(), "R9 R10 16-bit result");

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         compared++; mismatched++;
         $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
      end
      finish_run();
   end
endmodule